// File: doc/BRIEF.md
# Maskable Interrupt Controller with Acknowledge Sequencer

This block gathers a set of maskable interrupt sources into sticky pending flags. Each source has its own enable bit, and one global enable gates all of them. At every instruction boundary that the core signals, the block decides whether to take an interrupt. It takes one only when a source is both enabled and pending, the global enable is set, no non-maskable service is running and the next instruction is not marked for skipping.

A taken interrupt starts a fixed acknowledge sequence of seven cycles. On entry the global enable is cleared. The return address given by the core is pushed to an external stack, and in the last cycle the program counter is loaded with the fixed vector 0x00FF. A priority encoder reports the lowest-numbered source that is both enabled and pending, so that the handler can dispatch on it. A return-from-interrupt pulse sets the global enable again and pops the saved address. That address is then handed back to the core as a program-counter load.

The stack push and the stack pop are valid/ready transfers. The block raises `push_valid` and holds both it and `push_data` steady until `push_ready` is seen high on a clock edge. It raises `pop_valid` and holds it until `pop_ready` is high, and it takes `pop_data` in that same cycle. The stack may stall either transfer for any number of cycles. All other pins are plain level or pulse signals. Registers sit on a small write/read port: address 0 holds the enables, address 1 the pending flags, address 2 the control register (bit 0 is the global enable), and address 3 is a read-only index view.

Top module: `irq_seq_ctrl`

## Requirements
- R1: A high bit on `src_evt` sets the matching pending flag (read at address 1) on the next clock edge, whatever the state of the enable bit at address 0.
- R2: Writing address 1 clears every pending flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. No other action clears a pending flag. Address 0 is a plain read/write enable mask.
- R3: When a `src_evt` set and a write-one clear reach the same pending flag in one cycle, the flag ends up set.
- R4: `vec_valid` is high when some source is both enabled and pending. `vec_idx` then gives the lowest such index. Address 3 reads `vec_valid` in bit 7 and `vec_idx` in bits 2:0, with zeros elsewhere.
- R5: An interrupt is taken at a cycle with `insn_start` high only if address 2 bit 0 is set, `vec_valid` is high, `nmi_busy` is low and no sequence is running. Otherwise nothing starts.
- R6: A boundary with `skip_pend` high never starts an acknowledge. The interrupt is taken at the next boundary that has `skip_pend` low.
- R7: After a take, `ack_busy` is high for exactly 7 cycles, starting in the cycle after the boundary, when `push_ready` is held high. The global enable reads 0. `push_data` equals the `cur_pc` sampled at the boundary. `pc_load` pulses once, with `pc_value` equal to 0x00FF, in the last busy cycle. The pending flags are left unchanged.
- R8: While `push_ready` is low, `push_valid` and `push_data` stay steady and `ack_busy` stays high. Each acknowledge makes exactly one push.
- R9: While `ack_busy` is high, `insn_start` is ignored, and no second acknowledge follows once the first one completes.
- R10: A `reti` pulse while idle sets the global enable and raises `pop_valid` until `pop_ready` is high. In that cycle `pc_load` is high and `pc_value` equals `pop_data`.
- R11: After reset the enables, pending flags and global enable read 0, and `ack_busy`, `push_valid`, `pop_valid` and `pc_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 8 | Interrupt events, one bit per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_valid | output | 1 | Some source is enabled and pending |
| vec_idx | output | 3 | Index of the highest-priority active source |
| insn_start | input | 1 | Instruction boundary from the core |
| skip_pend | input | 1 | The next instruction will be skipped |
| nmi_busy | input | 1 | A non-maskable service is in progress |
| reti | input | 1 | Return-from-interrupt pulse |
| cur_pc | input | 16 | Address of the next instruction |
| ack_busy | output | 1 | Acknowledge sequence running; the core must hold |
| push_valid | output | 1 | Stack push request |
| push_ready | input | 1 | Stack accepts the push |
| push_data | output | 16 | Return address to push |
| pop_valid | output | 1 | Stack pop request |
| pop_ready | input | 1 | Stack supplies the pop data |
| pop_data | input | 16 | Popped return address |
| pc_load | output | 1 | Program-counter load strobe |
| pc_value | output | 16 | Program-counter load value |

## Verification
The hardest case to reach from the ports is a stack that holds back the push while the core keeps signalling boundaries during the acknowledge. To build it, the bench keeps `push_ready` low for the first ten busy cycles and holds `insn_start` high for the whole sequence. It then checks that the busy window stretches to the cycle of acceptance, that the pushed word never changes, and that exactly one push and one vector load occur. The priority encoder is swept over all 256 pending patterns under several enable masks, and the expected index is computed arithmetically. The skip, non-maskable and global-enable gates are each exercised on their own with everything else qualified.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_POP  = 2'd2
  } seq_state_e;

  localparam logic [1:0] REG_ENABLE = 2'd0;
  localparam logic [1:0] REG_PEND   = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;
  localparam logic [1:0] REG_INDEX  = 2'd3;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic [NSRC-1:0] pend_clr,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      // the event term is ORed in last, so a hardware set beats a clear
      pend_q <= (pend_q & ~pend_clr) | src_evt;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC = 8,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  output logic            valid,
  output logic [IW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign valid = |req;
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_seq_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          ACK_CYCLES = 7,
  parameter logic [AW-1:0] VEC_ADDR = 16'h00FF,
  localparam int CW = $clog2(ACK_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_start,
  input  logic          skip_pend,
  input  logic          nmi_busy,
  input  logic          reti,
  input  logic          irq_ready,
  input  logic          gie_wr,
  input  logic          gie_wdata,
  input  logic [AW-1:0] cur_pc,
  input  logic          push_ready,
  input  logic          pop_ready,
  input  logic [AW-1:0] pop_data,
  output logic          gie_q,
  output logic          ack_busy,
  output logic          push_valid,
  output logic [AW-1:0] push_data,
  output logic          pop_valid,
  output logic          pc_load,
  output logic [AW-1:0] pc_value
);
  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] ret_q;
  logic          pushed_q;
  logic          take, ret_go, push_fire, ack_done;

  assign take      = (state_q == ST_IDLE) && insn_start && !skip_pend && !nmi_busy
                     && gie_q && irq_ready && !reti;
  assign ret_go    = (state_q == ST_IDLE) && reti;
  assign push_fire = push_valid && push_ready;
  assign ack_done  = (state_q == ST_ACK) && (cnt_q == CW'(ACK_CYCLES - 1))
                     && (pushed_q || push_fire);

  assign ack_busy   = (state_q == ST_ACK);
  assign push_valid = (state_q == ST_ACK) && !pushed_q;
  assign push_data  = ret_q;
  assign pop_valid  = (state_q == ST_POP);

  always_comb begin
    pc_load  = 1'b0;
    pc_value = '0;
    if (ack_done) begin
      pc_load  = 1'b1;
      pc_value = VEC_ADDR;
    end else if (pop_valid && pop_ready) begin
      pc_load  = 1'b1;
      pc_value = pop_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ret_q    <= '0;
      pushed_q <= 1'b0;
      gie_q    <= 1'b0;
    end else begin
      if (take)        gie_q <= 1'b0;
      else if (ret_go) gie_q <= 1'b1;
      else if (gie_wr) gie_q <= gie_wdata;

      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q  <= ST_ACK;
            cnt_q    <= '0;
            ret_q    <= cur_pc;
            pushed_q <= 1'b0;
          end else if (ret_go) begin
            state_q <= ST_POP;
          end
        end
        ST_ACK: begin
          if (push_fire) pushed_q <= 1'b1;
          if (cnt_q != CW'(ACK_CYCLES - 1)) cnt_q <= cnt_q + 1'b1;
          if (ack_done) state_q <= ST_IDLE;
        end
        ST_POP: begin
          if (pop_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int            NSRC       = 8,
  parameter int            AW         = 16,
  parameter int            ACK_CYCLES = 7,
  parameter logic [AW-1:0] VEC_ADDR   = 16'h00FF,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            reg_wr_en,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            vec_valid,
  output logic [IW-1:0]   vec_idx,
  input  logic            insn_start,
  input  logic            skip_pend,
  input  logic            nmi_busy,
  input  logic            reti,
  input  logic [AW-1:0]   cur_pc,
  output logic            ack_busy,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [AW-1:0]   push_data,
  output logic            pop_valid,
  input  logic            pop_ready,
  input  logic [AW-1:0]   pop_data,
  output logic            pc_load,
  output logic [AW-1:0]   pc_value
);
  logic [NSRC-1:0] en_q, pend_q, pend_clr, index_view;
  logic            gie_q;

  assign pend_clr = (reg_wr_en && reg_addr == REG_PEND) ? reg_wdata : '0;

  irq_pend_bank #(.NSRC(NSRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_evt  (src_evt),
    .en_wr    (reg_wr_en && reg_addr == REG_ENABLE),
    .en_wdata (reg_wdata),
    .pend_clr (pend_clr),
    .en_q     (en_q),
    .pend_q   (pend_q)
  );

  irq_prio_enc #(.NSRC(NSRC)) u_enc (
    .req   (en_q & pend_q),
    .valid (vec_valid),
    .idx   (vec_idx)
  );

  irq_ack_fsm #(.AW(AW), .ACK_CYCLES(ACK_CYCLES), .VEC_ADDR(VEC_ADDR)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_start (insn_start),
    .skip_pend  (skip_pend),
    .nmi_busy   (nmi_busy),
    .reti       (reti),
    .irq_ready  (vec_valid),
    .gie_wr     (reg_wr_en && reg_addr == REG_CTRL),
    .gie_wdata  (reg_wdata[0]),
    .cur_pc     (cur_pc),
    .push_ready (push_ready),
    .pop_ready  (pop_ready),
    .pop_data   (pop_data),
    .gie_q      (gie_q),
    .ack_busy   (ack_busy),
    .push_valid (push_valid),
    .push_data  (push_data),
    .pop_valid  (pop_valid),
    .pc_load    (pc_load),
    .pc_value   (pc_value)
  );

  always_comb begin
    index_view              = '0;
    index_view[IW-1:0]      = vec_idx;
    index_view[NSRC-1]      = vec_valid;
  end

  always_comb begin
    unique case (reg_addr)
      REG_ENABLE: reg_rdata = en_q;
      REG_PEND:   reg_rdata = pend_q;
      REG_CTRL:   reg_rdata = {{(NSRC-1){1'b0}}, gie_q};
      default:    reg_rdata = index_view;
    endcase
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int            NSRC       = 8,
  parameter int            AW         = 16,
  parameter int            ACK_CYCLES = 7,
  parameter logic [AW-1:0] VEC_ADDR   = 16'h00FF
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_evt,
  input logic            reg_wr_en,
  input logic [1:0]      reg_addr,
  input logic            insn_start,
  input logic            skip_pend,
  input logic            nmi_busy,
  input logic            ack_busy,
  input logic            push_valid,
  input logic            push_ready,
  input logic [AW-1:0]   push_data,
  input logic            pop_valid,
  input logic            pc_load,
  input logic [AW-1:0]   pc_value,
  input logic [NSRC-1:0] pend_q,
  input logic            gie_q
);
  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (ack_busy) run_q <= run_q + 8'd1;
    else               run_q <= '0;
  end

  // R1
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  // R2
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == 2'd1) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R6
  take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_busy) |-> $past(insn_start && !skip_pend && !nmi_busy));

  // R7
  gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_busy) |-> !gie_q);

  // R7
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && ack_busy) |-> (pc_value == VEC_ADDR));

  // R7
  ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_busy) |-> (run_q >= 8'(ACK_CYCLES)));

  // R8
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

  // R10
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_valid, pop_valid}));
endmodule

bind irq_seq_ctrl irq_seq_chk #(
  .NSRC(NSRC), .AW(AW), .ACK_CYCLES(ACK_CYCLES), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_evt    (src_evt),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .insn_start (insn_start),
  .skip_pend  (skip_pend),
  .nmi_busy   (nmi_busy),
  .ack_busy   (ack_busy),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .push_data  (push_data),
  .pop_valid  (pop_valid),
  .pc_load    (pc_load),
  .pc_value   (pc_value),
  .pend_q     (pend_q),
  .gie_q      (gie_q)
);

// File: tb/tb_irq_seq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_seq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  src_evt = 0;
  logic        reg_wr_en = 0;
  logic [1:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        vec_valid;
  logic [2:0]  vec_idx;
  logic        insn_start = 0, skip_pend = 0, nmi_busy = 0, reti = 0;
  logic [15:0] cur_pc = 0;
  logic        ack_busy, push_valid, pop_valid, pc_load;
  logic        push_ready = 1, pop_ready = 0;
  logic [15:0] push_data, pop_data = 0, pc_value;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  irq_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_valid(vec_valid), .vec_idx(vec_idx), .insn_start(insn_start),
    .skip_pend(skip_pend), .nmi_busy(nmi_busy), .reti(reti), .cur_pc(cur_pc),
    .ack_busy(ack_busy), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .pc_load(pc_load), .pc_value(pc_value)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] p);
    @(negedge clk); src_evt = p;
    @(negedge clk); src_evt = 0;
  endtask

  // drives a boundary and watches the busy window
  task automatic run_ack(input logic [15:0] pc, input int stall, input bit hold_insn,
                         output int nbusy, output int npush, output logic [15:0] pdata,
                         output int nload, output logic [15:0] lval);
    @(negedge clk); insn_start = 1; cur_pc = pc;
    @(negedge clk); insn_start = hold_insn;
    nbusy = 0; npush = 0; nload = 0; pdata = 0; lval = 0;
    while (ack_busy && nbusy < 60) begin
      nbusy++;
      push_ready = (nbusy > stall);
      #0.5;
      if (push_valid && push_ready) begin npush++; pdata = push_data; end
      if (pc_load) begin nload++; lval = pc_value; end
      if (stall > 0 && push_valid && !push_ready && nbusy > 1)
        chk(push_data == pc, "R8 push_data steady", push_data, pc);
      @(negedge clk);
    end
    insn_start = 0; push_ready = 1;
  endtask

  int nb, np, nl;
  logic [15:0] pd, lv;
  logic [7:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(0, r); chk(r == 0, "R11 enable", r, 0);
    rd(1, r); chk(r == 0, "R11 pending", r, 0);
    rd(2, r); chk(r == 0, "R11 gie", r, 0);
    chk({ack_busy, push_valid, pop_valid, pc_load} == 0, "R11 outputs",
        {ack_busy, push_valid, pop_valid, pc_load}, 0);

    // R1 R2 R4 sweep
    begin
      logic [7:0] masks [4] = '{8'hFF, 8'h0F, 8'hA5, 8'h80};
      for (int m = 0; m < 4; m++) begin
        wr(0, masks[m]);
        for (int p = 0; p < 256; p++) begin
          logic [7:0] act_b;
          int exp_i;
          pulse_evt(p[7:0]);
          act_b = masks[m] & p[7:0];
          exp_i = 0;
          for (int b = 7; b >= 0; b--) if (act_b[b]) exp_i = b;
          rd(1, r); chk(r == p[7:0], "R1 pending set", r, p);
          chk(vec_valid == (act_b != 0), "R4 vec_valid", vec_valid, act_b != 0);
          if (act_b != 0) chk(vec_idx == exp_i[2:0], "R4 vec_idx", vec_idx, exp_i);
          rd(3, r);
          chk(r == {(act_b != 0), 4'b0, (act_b != 0) ? exp_i[2:0] : 3'b0},
              "R4 index view", r, {(act_b != 0), 4'b0, exp_i[2:0]});
          wr(1, 8'hFF);
          rd(1, r); chk(r == 0, "R2 w1c clear", r, 0);
        end
      end
      rd(0, r); chk(r == 8'h80, "R2 enable readback", r, 8'h80);
    end

    // R2 partial clear, R3 set beats clear
    pulse_evt(8'h3C);
    wr(1, 8'h14);
    rd(1, r); chk(r == 8'h28, "R2 partial w1c", r, 8'h28);
    @(negedge clk); reg_wr_en = 1; reg_addr = 1; reg_wdata = 8'h28; src_evt = 8'h08;
    @(negedge clk); reg_wr_en = 0; src_evt = 0;
    rd(1, r); chk(r == 8'h08, "R3 set wins", r, 8'h08);
    wr(1, 8'hFF);

    // R5 gating
    wr(0, 8'h04); pulse_evt(8'h04);
    run_ack(16'h0100, 0, 0, nb, np, pd, nl, lv);
    chk(nb == 0, "R5 no take gie=0", nb, 0);
    wr(2, 8'h01); nmi_busy = 1;
    run_ack(16'h0100, 0, 0, nb, np, pd, nl, lv);
    chk(nb == 0, "R5 no take nmi", nb, 0);
    nmi_busy = 0; wr(0, 8'h00);
    run_ack(16'h0100, 0, 0, nb, np, pd, nl, lv);
    chk(nb == 0, "R5 no take disabled", nb, 0);

    // R6 skip defers
    wr(0, 8'hFF); pulse_evt(8'h08);
    skip_pend = 1;
    run_ack(16'h0100, 0, 0, nb, np, pd, nl, lv);
    chk(nb == 0, "R6 skipped boundary", nb, 0);
    skip_pend = 0;

    // R7 acknowledge
    run_ack(16'h1234, 0, 0, nb, np, pd, nl, lv);
    chk(nb == 7, "R7 busy length", nb, 7);
    chk(np == 1 && pd == 16'h1234, "R7 pushed pc", pd, 16'h1234);
    chk(nl == 1 && lv == 16'h00FF, "R7 vector load", lv, 16'h00FF);
    rd(2, r); chk(r == 0, "R7 gie cleared", r, 0);
    rd(1, r); chk(r == 8'h0C, "R7 pending kept", r, 8'h0C);
    chk(vec_idx == 3'd2, "R7 index after take", vec_idx, 2);

    // R10 return
    @(negedge clk); reti = 1; pop_ready = 0;
    @(negedge clk); reti = 0;
    rd(2, r); chk(r == 1, "R10 gie set", r, 1);
    repeat (3) begin
      chk(pop_valid == 1, "R10 pop held", pop_valid, 1);
      @(negedge clk);
    end
    pop_data = 16'h1234; pop_ready = 1; #0.5;
    chk(pc_load == 1 && pc_value == 16'h1234, "R10 pc restore", pc_value, 16'h1234);
    @(negedge clk); pop_ready = 0;
    chk(pop_valid == 0, "R10 pop done", pop_valid, 0);

    // R8 R9 stalled push with boundaries during busy
    run_ack(16'hBEEF, 10, 1, nb, np, pd, nl, lv);
    chk(nb == 11, "R8 busy extends", nb, 11);
    chk(np == 1 && pd == 16'hBEEF, "R8 one push", np, 1);
    chk(nl == 1 && lv == 16'h00FF, "R9 one vector load", nl, 1);
    @(negedge clk);
    chk(ack_busy == 0, "R9 no second ack", ack_busy, 0);

    finish_run();
  end
endmodule